// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates one 32-bit virtual address into a 32-bit physical address by reading a two-level page table from memory. The pages are 4 KB. A requester presents a virtual address, an access kind (read, write or execute) and the physical base address of the page directory. The walker then makes two word reads through a simple request/acknowledge memory port. The first read fetches the directory entry and the second fetches the table entry. The walker returns the physical address together with the permission bits of the page. If a walk cannot complete, it returns a fault code instead.

The virtual address splits into three fields. Bits [31:22] index the directory, bits [21:12] index the table and bits [11:0] are the byte offset. Directory and table entries share one layout: the frame number is in bits [31:12], valid is bit 0, read is bit 1, write is bit 2, execute is bit 3 and dirty is bit 4. A permitted write to a page whose dirty bit is clear makes the walker write the table entry back with dirty set before it reports completion. Only one walk runs at a time, and a busy output holds off further requests.

Top module: `ptw_walker`

## Requirements
- R1: After reset, busy, done, fault and mem_req are all 0.
- R2: The first memory read of a walk goes to pt_base + 4 × req_vaddr[31:22].
- R3: When the directory entry is valid, the second read goes to (directory entry [31:12] << 12) + 4 × req_vaddr[21:12].
- R4: On success, done pulses for one cycle with resp_paddr = {table entry [31:12], req_vaddr[11:0]}, resp_perm = {execute, write, read} bits of the table entry, fault low and fault_code 0.
- R5: A directory entry with bit 0 clear ends the walk with a one-cycle fault pulse and fault_code 1, and no table read is made.
- R6: A valid directory entry followed by a table entry with bit 0 clear gives a fault pulse with fault_code 2.
- R7: req_kind is encoded as 0 read, 1 write, 2 execute and 3 reserved. A valid table entry whose read (bit 1), write (bit 2) or execute (bit 3) bit does not allow the requested kind gives a fault with fault_code 3. Kind 3 always gives fault_code 3.
- R8: A permitted write to a table entry with bit 4 clear issues one memory write to the table entry address, with data equal to the entry with bit 4 set. done pulses only after that write is acknowledged.
- R9: No memory write is made for reads, for executes, for faulting walks, or for writes to an entry whose bit 4 is already set.
- R10: busy is high from the cycle after a request is accepted until the cycle in which done or fault pulses. A request presented while busy is high is ignored.
- R11: mem_req, together with mem_we, mem_addr and mem_wdata, holds steady from the time it rises until mem_ack is seen.
- R12: A request presented in the cycle in which done pulses is accepted and walked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| pt_base | input | 32 | Physical address of the page directory |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: translation ready |
| fault | output | 1 | One-cycle pulse: walk ended in a fault |
| fault_code | output | 2 | 0 none, 1 directory not present, 2 page not present, 3 protection |
| resp_paddr | output | 32 | Translated physical address, valid with done |
| resp_perm | output | 3 | {execute, write, read} bits of the page, valid with done |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; for reads, mem_rdata is valid with it |
| mem_rdata | input | 32 | Read data |

## Verification
Two events can coincide. The end of one walk (the done pulse, with busy dropping) can fall in the same cycle as the arrival of the next request. The bench raises req_valid in exactly the cycle in which it sees done, then checks both translations and the read addresses of the second walk. The opposite case, a request arriving mid-walk, is provoked as well: a second request is presented while busy is high. The bench then checks that only the first walk's two reads occur and that no further result follows. The dirty write-back is timed against done by checking that the write has been logged before done is observed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int ENT_LG = 2;
  localparam int FRM_W  = PA_W - OFF_W;
  localparam int B_V    = 0;
  localparam int B_R    = 1;
  localparam int B_W    = 2;
  localparam int B_X    = 3;
  localparam int B_D    = 4;
  localparam int FLAG_W = B_D + 1;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_RSV = 2'd3} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_DIR = 2'd1, FLT_PAGE = 2'd2, FLT_PROT = 2'd3} flt_e;

  function automatic logic [PA_W-1:0] dir_entry_addr(input logic [PA_W-1:0] base,
                                                     input logic [IDX_W-1:0] didx);
    return base + PA_W'({didx, {ENT_LG{1'b0}}});
  endfunction

  function automatic logic [PA_W-1:0] tbl_entry_addr(input logic [FRM_W-1:0] frame,
                                                     input logic [IDX_W-1:0] tidx);
    return {frame, {OFF_W{1'b0}}} + PA_W'({tidx, {ENT_LG{1'b0}}});
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [FRM_W-1:0] frame,
                                                input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  acc_e              kind,
  output logic              allow,
  output logic              need_dirty
);
  logic kind_ok;

  always_comb begin
    case (kind)
      ACC_RD:  kind_ok = flags[B_R];
      ACC_WR:  kind_ok = flags[B_W];
      ACC_EX:  kind_ok = flags[B_X];
      default: kind_ok = 1'b0;
    endcase
    allow      = flags[B_V] && kind_ok;
    need_dirty = allow && (kind == ACC_WR) && !flags[B_D];
  end
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  acc_e              req_kind,
  input  logic [PA_W-1:0]   pt_base,
  input  logic              mem_ack,
  input  logic [PA_W-1:0]   mem_rdata,
  input  logic              allow,
  input  logic              need_dirty,
  output acc_e              kind_q,
  output logic [FLAG_W-1:0] ent_flags,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output flt_e              fault_code,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [2:0]        resp_perm,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PA_W-1:0]   mem_wdata
);
  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_WB} st_e;

  st_e              st;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  tbl_addr_q;
  logic [PA_W-1:0]  pte_q;
  logic [IDX_W-1:0] didx, tidx;
  logic [OFF_W-1:0] off;

  // named internal events
  logic start_ev, dir_ev, tbl_ev, wb_ev;
  assign start_ev = (st == S_IDLE) && req_valid;
  assign dir_ev   = (st == S_DIR) && mem_ack;
  assign tbl_ev   = (st == S_TBL) && mem_ack;
  assign wb_ev    = (st == S_WB) && mem_ack;

  assign didx      = va_q[VA_W-1 -: IDX_W];
  assign tidx      = va_q[OFF_W +: IDX_W];
  assign off       = va_q[OFF_W-1:0];
  assign ent_flags = mem_rdata[FLAG_W-1:0];
  assign busy      = (st != S_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_DIR) ? dir_entry_addr(base_q, didx) : tbl_addr_q;
  assign mem_wdata = (st == S_WB) ? (pte_q | (PA_W'(1) << B_D)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      base_q     <= '0;
      kind_q     <= ACC_RD;
      tbl_addr_q <= '0;
      pte_q      <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
      resp_paddr <= '0;
      resp_perm  <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (start_ev) begin
        va_q   <= req_vaddr;
        base_q <= pt_base;
        kind_q <= req_kind;
        st     <= S_DIR;
      end
      if (dir_ev) begin
        if (!mem_rdata[B_V]) begin
          fault      <= 1'b1;
          fault_code <= FLT_DIR;
          st         <= S_IDLE;
        end else begin
          tbl_addr_q <= tbl_entry_addr(mem_rdata[PA_W-1:OFF_W], tidx);
          st         <= S_TBL;
        end
      end
      if (tbl_ev) begin
        if (!mem_rdata[B_V]) begin
          fault      <= 1'b1;
          fault_code <= FLT_PAGE;
          st         <= S_IDLE;
        end else if (!allow) begin
          fault      <= 1'b1;
          fault_code <= FLT_PROT;
          st         <= S_IDLE;
        end else begin
          resp_paddr <= phys_addr(mem_rdata[PA_W-1:OFF_W], off);
          resp_perm  <= {mem_rdata[B_X], mem_rdata[B_W], mem_rdata[B_R]};
          fault_code <= FLT_NONE;
          pte_q      <= mem_rdata;
          if (need_dirty) begin
            st <= S_WB;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
      end
      if (wb_ev) begin
        done <= 1'b1;
        st   <= S_IDLE;
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !done && !fault);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && !mem_ack |=> $stable(va_q) && $stable(kind_q));

  a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fault));

  a_r8_wb_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[B_D] && mem_wdata[B_V] && mem_wdata[B_W] && kind_q == ACC_WR);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !done && !fault);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic [31:0] pt_base,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [1:0]  fault_code,
  output logic [31:0] resp_paddr,
  output logic [2:0]  resp_perm,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  acc_e              kind_q;
  flt_e              code;
  logic [FLAG_W-1:0] flags;
  logic              allow, need_dirty;

  ptw_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_kind   (acc_e'(req_kind)),
    .pt_base    (pt_base),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .allow      (allow),
    .need_dirty (need_dirty),
    .kind_q     (kind_q),
    .ent_flags  (flags),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_code (code),
    .resp_paddr (resp_paddr),
    .resp_perm  (resp_perm),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  ptw_check u_chk (
    .flags      (flags),
    .kind       (kind_q),
    .allow      (allow),
    .need_dirty (need_dirty)
  );

  assign fault_code = code;
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [31:0] req_vaddr = 0, pt_base = 0;
  logic [1:0] req_kind = 0;
  logic busy, done, fault, mem_req, mem_we;
  logic [1:0] fault_code;
  logic [31:0] resp_paddr, mem_addr, mem_wdata;
  logic [2:0] resp_perm;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = 0;

  ptw_walker u0 (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] ma [16];
  logic [31:0] md [16];
  int mn = 0;
  int lat = 0, cnt = 0, pend = 0, stab_err = 0;
  logic [31:0] h_a, h_d;
  logic h_we;
  int rd_count = 0, wr_count = 0;
  logic [31:0] rd_addr [4];
  logic [31:0] wr_addr, wr_data;
  logic r_done, r_fault;
  logic [1:0] r_code;
  logic [31:0] r_paddr;
  logic [2:0] r_perm;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < mn; i++) if (ma[i] == a) return md[i];
    return 32'h0;
  endfunction

  task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
    for (int i = 0; i < mn; i++) if (ma[i] == a) begin md[i] = d; return; end
    ma[mn] = a; md[mn] = d; mn++;
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (pend == 0) begin pend = 1; cnt = 0; h_a = mem_addr; h_we = mem_we; h_d = mem_wdata; end
      else if (mem_addr !== h_a || mem_we !== h_we || mem_wdata !== h_d) stab_err++;
      if (cnt >= lat) begin
        if (mem_we) begin
          mem_put(mem_addr, mem_wdata); wr_addr = mem_addr; wr_data = mem_wdata; wr_count++;
        end else begin
          if (rd_count < 4) rd_addr[rd_count] = mem_addr;
          rd_count++;
          mem_rdata = lookup(mem_addr);
        end
        mem_ack = 1; pend = 0;
      end else cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_a(input logic [31:0] b, input logic [31:0] va);
    return b + ((va >> 22) << 2);
  endfunction
  function automatic logic [31:0] tbl_a(input logic [31:0] pde, input logic [31:0] va);
    return (pde & 32'hFFFFF000) + (((va >> 12) & 32'h3FF) * 4);
  endfunction
  function automatic logic [31:0] pa_of(input logic [31:0] pte, input logic [31:0] va);
    return (pte & 32'hFFFFF000) | (va & 32'hFFF);
  endfunction

  task automatic clear_log();
    rd_count = 0; wr_count = 0; wr_addr = 0; wr_data = 0;
    for (int i = 0; i < 4; i++) rd_addr[i] = 32'hx;
  endtask

  task automatic start_req(input logic [31:0] va, input logic [1:0] k);
    req_valid = 1; req_vaddr = va; req_kind = k;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_end();
    r_done = 0; r_fault = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done || fault) begin
        r_done = done; r_fault = fault; r_code = fault_code;
        r_paddr = resp_paddr; r_perm = resp_perm;
        return;
      end
    end
    errors++; checks++;
    $display("FAIL timeout actual=none expected=done_or_fault");
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] k, input int l);
    lat = l;
    @(negedge clk);
    clear_log();
    start_req(va, k);
    wait_end();
  endtask

  localparam logic [31:0] BASE = 32'h10005000;
  localparam logic [31:0] VA1 = 32'h7192a44c, PDE1 = 32'h12345001, PTE1 = 32'h14817007;
  localparam logic [31:0] VA2 = 32'h00403123, PDE2 = 32'h22222001, PTE2 = 32'h0ABCD00B;
  localparam logic [31:0] VA3 = 32'h00800abc, PDE3 = 32'h33333000;
  localparam logic [31:0] VA4 = 32'h00405fff, PTE4 = 32'h55555006;
  localparam logic [31:0] VA5 = 32'h00406010, PTE5 = 32'h66666013;

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 fault", fault, 0); chk("R1 mem_req", mem_req, 0);
  endtask

  task automatic t_read_hit();
    walk(VA1, 2'd0, 1);
    chk("R2 dir addr", rd_addr[0], dir_a(BASE, VA1));
    chk("R3 tbl addr", rd_addr[1], tbl_a(PDE1, VA1));
    chk("R4 done", r_done, 1); chk("R4 fault", r_fault, 0);
    chk("R4 paddr", r_paddr, 32'h1481744c);
    chk("R4 perm", r_perm, 3'b011); chk("R4 code", r_code, 0);
    chk("R9 no write on read", wr_count, 0);
  endtask

  task automatic t_dirty_write();
    walk(VA1, 2'd1, 2);
    chk("R8 done", r_done, 1);
    chk("R8 write before done", wr_count, 1);
    chk("R8 wr addr", wr_addr, tbl_a(PDE1, VA1));
    chk("R8 wr data", wr_data, 32'h14817017);
    chk("R8 paddr", r_paddr, pa_of(PTE1, VA1));
  endtask

  task automatic t_write_dirty_page();
    walk(VA1, 2'd1, 0);
    chk("R9 done", r_done, 1);
    chk("R9 no write when dirty", wr_count, 0);
  endtask

  task automatic t_exec();
    walk(VA1, 2'd2, 0);
    chk("R7 exec denied", {r_fault, r_code}, {1'b1, 2'd3});
    chk("R9 no write on fault", wr_count, 0);
    walk(VA2, 2'd2, 1);
    chk("R7 exec ok", r_done, 1);
    chk("R4 paddr2", r_paddr, pa_of(PTE2, VA2));
    chk("R4 perm2", r_perm, 3'b101);
    chk("R9 no write exec", wr_count, 0);
    walk(VA1, 2'd3, 0);
    chk("R7 reserved kind", {r_fault, r_code}, {1'b1, 2'd3});
  endtask

  task automatic t_faults();
    walk(VA3, 2'd0, 1);
    chk("R5 dir fault", {r_fault, r_done, r_code}, {1'b1, 1'b0, 2'd1});
    chk("R5 one read", rd_count, 1);
    walk(VA4, 2'd0, 0);
    chk("R6 page fault", {r_fault, r_code}, {1'b1, 2'd2});
    chk("R6 tbl addr", rd_addr[1], tbl_a(PDE2, VA4));
    walk(VA5, 2'd1, 1);
    chk("R7 write denied", {r_fault, r_code}, {1'b1, 2'd3});
    chk("R9 no write denied", wr_count, 0);
    walk(VA5, 2'd0, 0);
    chk("R7 read ok", r_done, 1);
    chk("R4 perm ro", r_perm, 3'b001);
  endtask

  task automatic t_busy_ignore();
    int seen;
    lat = 2;
    @(negedge clk);
    clear_log();
    start_req(VA1, 2'd0);
    chk("R10 busy", busy, 1);
    req_valid = 1; req_vaddr = VA3; req_kind = 2'd1;
    @(negedge clk);
    req_valid = 0;
    wait_end();
    chk("R10 first result", r_paddr, 32'h1481744c);
    chk("R10 busy low at end", busy, 0);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done || fault || busy) seen++;
    end
    chk("R10 ignored request", seen, 0);
    chk("R10 reads", rd_count, 2);
  endtask

  task automatic t_back_to_back();
    walk(VA2, 2'd0, 1);
    chk("R12 first", r_paddr, pa_of(PTE2, VA2));
    clear_log();
    start_req(VA1, 2'd0);
    wait_end();
    chk("R12 second done", r_done, 1);
    chk("R12 second paddr", r_paddr, 32'h1481744c);
    chk("R12 second dir addr", rd_addr[0], dir_a(BASE, VA1));
  endtask

  initial begin
    mem_put(dir_a(BASE, VA1), PDE1); mem_put(tbl_a(PDE1, VA1), PTE1);
    mem_put(dir_a(BASE, VA2), PDE2); mem_put(tbl_a(PDE2, VA2), PTE2);
    mem_put(dir_a(BASE, VA3), PDE3);
    mem_put(tbl_a(PDE2, VA4), PTE4); mem_put(tbl_a(PDE2, VA5), PTE5);
    pt_base = BASE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_dirty_write();
    t_write_dirty_page();
    t_exec();
    t_faults();
    t_busy_ignore();
    t_back_to_back();
    chk("R11 request stable", stab_err, 0);
    finish_run();
  end
endmodule